// File: doc/BRIEF.md
# DMA Channel Control and Address Engine

This block is the control front end of a single DMA channel. Software programs it through a small word-addressed register bus. It writes a control/status word, a start address and a byte count there. The engine then issues memory requests, and each request moves a block of bytes whose size comes from the selected burst mode and the bytes still left. After each accepted request the address and the count advance. When the count reaches zero a terminal-count flag is raised.

A small pack counter tracks bytes that a device has handed in but that do not yet fill a word. A drain command turns those leftover bytes into single-byte memory writes. A flush command wipes the error, terminal-count and pack state. A sticky reset bit holds the channel idle until software clears it. Slave errors reported by the memory port stop the channel and raise error pending. The interrupt output combines the interrupt and error flags under an enable bit.

Only the low part of the address counts, 24 bits by default. The bits above it keep the value software wrote, so a transfer that crosses a 16 MB line wraps within its window instead of carrying upward.

Top module: `dmac_engine`

## Requirements
- R1: Control word reads return the revision constant (default 0xA) in bits 31:28. Bits 27:24, 22:20, 17:15 and 13:10 read as zero, and bit 5 always reads 0. Software-written fields are bit 23 (terminal-count interrupt mask), bits 19:18 (burst), bit 9 (enable), bit 8 (direction), bit 7 (reset) and bit 4 (interrupt enable). Writes to every other bit do not change their read value.
- R2: Each accepted request adds mem_len to the low 24 address bits, modulo 2^24. Bits 31:24 never change except through an address write.
- R3: Each accepted request subtracts mem_len from the byte count. The terminal-count flag (control bit 14) sets when an accepted request brings the count from nonzero to zero, and it stays set until a flush or the reset bit clears it.
- R4: In normal transfers mem_len is the burst size, capped at the remaining count. Burst field 00 gives 16 bytes, 01 gives 32 bytes, and 10 or 11 gives 1 byte.
- R5: Without a drain in progress, mem_req is high only when enable is 1, reset is 0, no slave error is pending and the count is nonzero. mem_wr equals the direction bit, where 1 means device to memory.
- R6: The reset bit (bit 7) reads back 1 until software writes 0. While it is set, mem_req stays low, and the terminal-count, error, slave-error, pack and drain state is cleared.
- R7: Writing 1 to bit 5 of the control word (flush) clears error pending, slave error, terminal count, the pack count and any drain in progress on the next clock edge.
- R8: Writing 1 to bit 6 of the control word starts a drain. The pack count moves into bits 3:2 of the control word. The engine then issues 1-byte requests regardless of enable, and each accepted request lowers bits 3:2 by one. Read bit 6 shows slave error, never the command.
- R9: A dev_push pulse raises the pack count by one, modulo 4, only while enable is 1, direction is 1 and reset is 0.
- R10: mem_err high during a request sets error pending (bit 1) and slave error (bit 6). No bytes move in that cycle, and mem_req stays low until a flush or reset.
- R11: Interrupt pending (bit 0) is dev_irq OR (terminal count AND NOT bit 23). irq is bit 4 AND (bit 0 OR bit 1).
- R12: Register offsets are 0 for control, 1 for address, 2 for byte count and 3 for the diagnostic word, which reads 0 and ignores writes. Reads are combinational and writes take effect at the clock edge. A register write wins over a same-cycle transfer update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 2 | Register word offset |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| dev_push | input | 1 | Device delivered one byte into the pack register |
| dev_irq | input | 1 | Device interrupt request level |
| mem_req | output | 1 | Memory request valid |
| mem_addr | output | 32 | Current transfer address |
| mem_len | output | 6 | Bytes moved by the current request |
| mem_wr | output | 1 | 1 = memory write (device to memory) |
| mem_ack | input | 1 | Memory accepted the request |
| mem_err | input | 1 | Memory reported a slave error |
| irq | output | 1 | Combined interrupt output |

## Verification
The bench walks each burst mode against counts that are above, equal to and below the burst size. It includes two transfers whose addresses sit just under a 16 MB line. A design that carried into the upper byte would corrupt the upper address, and one that ignored the count cap would drive the count negative and miss the terminal-count flag. Directed tests then check several things: that the reset bit is sticky and blocks requests, that a slave error stops the channel without moving bytes until a flush, and that the mask bit hides terminal count from interrupt pending while leaving the flag visible. They also check that pack bytes wrap modulo 4, are ignored in the memory-to-device direction, and drain out one at a time.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

   // Largest burst in bytes and the width needed to express it
   localparam int BURST_BIG = 32;
   localparam int LEN_W     = $clog2(BURST_BIG) + 1;

   // Control word bit positions (software-visible layout)
   localparam int B_REV_LO  = 28;
   localparam int B_TCMASK  = 23;
   localparam int B_BURST   = 18;
   localparam int B_TC      = 14;
   localparam int B_EN      = 9;
   localparam int B_DIR     = 8;
   localparam int B_RST     = 7;
   localparam int B_DRAIN   = 6;   // write: drain command; read: slave error
   localparam int B_FLUSH   = 5;
   localparam int B_IE      = 4;
   localparam int B_DRN_LO  = 2;
   localparam int B_EP      = 1;
   localparam int B_IP      = 0;

   typedef enum logic [1:0] {
      BURST_16   = 2'b00,
      BURST_32   = 2'b01,
      BURST_NONE = 2'b10,
      BURST_RSV  = 2'b11
   } burst_e;

   typedef enum logic [1:0] {
      REG_CSR   = 2'd0,
      REG_ADDR  = 2'd1,
      REG_COUNT = 2'd2,
      REG_DIAG  = 2'd3
   } reg_e;

   function automatic logic [LEN_W-1:0] burst_bytes(burst_e b);
      case (b)
         BURST_16: return LEN_W'(16);
         BURST_32: return LEN_W'(32);
         default:  return LEN_W'(1);
      endcase
   endfunction

endpackage

// File: rtl/dmac_addr_ctr.sv
module dmac_addr_ctr #(
   parameter int ADDR_W = 32,
   parameter int INC_W  = 24,
   parameter int STEP_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic [ADDR_W-1:0] ld_val,
   input  logic              adv,
   input  logic [STEP_W-1:0] step,
   output logic [ADDR_W-1:0] addr
);

   generate
      if (INC_W >= ADDR_W) begin : g_full
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   addr <= '0;
            else if (ld)  addr <= ld_val;
            else if (adv) addr <= addr + ADDR_W'(step);
         end
      end else begin : g_split
         logic [ADDR_W-INC_W-1:0] hi_q;
         logic [INC_W-1:0]        lo_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hi_q <= '0;
               lo_q <= '0;
            end else if (ld) begin
               hi_q <= ld_val[ADDR_W-1:INC_W];
               lo_q <= ld_val[INC_W-1:0];
            end else if (adv) begin
               lo_q <= lo_q + INC_W'(step);
            end
         end
         assign addr = {hi_q, lo_q};
      end
   endgenerate

endmodule

// File: rtl/dmac_byte_ctr.sv
module dmac_byte_ctr #(
   parameter int CNT_W  = 24,
   parameter int STEP_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   input  logic             dec,
   input  logic [STEP_W-1:0] step,
   input  logic             clr_tc,
   output logic [CNT_W-1:0] count,
   output logic             tc
);

   logic [CNT_W-1:0] step_ext;
   logic [CNT_W-1:0] count_nxt;
   logic             hits_zero;

   always_comb begin
      step_ext  = CNT_W'(step);
      count_nxt = (step_ext >= count) ? '0 : count - step_ext;
      hits_zero = dec && (count != '0) && (count_nxt == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (ld)  count <= ld_val;
      else if (dec) count <= count_nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         tc <= 1'b0;
      else if (clr_tc)    tc <= 1'b0;
      else if (hits_zero) tc <= 1'b1;
   end

endmodule

// File: rtl/dmac_pack.sv
module dmac_pack #(
   parameter int PC_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            push,
   input  logic            drain,
   input  logic            take,
   output logic [PC_W-1:0] drain_cnt
);

   logic [PC_W-1:0] pack_q;
   logic            start;

   assign start = drain && (pack_q != '0) && (drain_cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pack_q    <= '0;
         drain_cnt <= '0;
      end else if (clr) begin
         pack_q    <= '0;
         drain_cnt <= '0;
      end else begin
         if (start) begin
            drain_cnt <= pack_q;
            pack_q    <= PC_W'(push);
         end else begin
            pack_q <= pack_q + PC_W'(push);
            if (take && drain_cnt != '0) drain_cnt <= drain_cnt - 1'b1;
         end
      end
   end

endmodule

// File: rtl/dmac_engine.sv
module dmac_engine
   import dmac_pkg::*;
#(
   parameter int         DATA_W = 32,
   parameter int         ADDR_W = 32,
   parameter int         INC_W  = 24,
   parameter int         CNT_W  = 24,
   parameter logic [3:0] REV    = 4'hA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_sel,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              dev_push,
   input  logic              dev_irq,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [LEN_W-1:0]  mem_len,
   output logic              mem_wr,
   input  logic              mem_ack,
   input  logic              mem_err,
   output logic              irq
);

   localparam int PC_W = 2;

   // Elaboration-time parameter checks
   generate
      if (DATA_W != 32) begin : g_bad_data_w
         $error("dmac_engine: control word layout needs DATA_W == 32");
      end
      if (ADDR_W > DATA_W) begin : g_bad_addr_w
         $error("dmac_engine: ADDR_W must not exceed DATA_W");
      end
      if (INC_W < LEN_W || INC_W > ADDR_W) begin : g_bad_inc_w
         $error("dmac_engine: INC_W out of range");
      end
      if (CNT_W < LEN_W || CNT_W > DATA_W) begin : g_bad_cnt_w
         $error("dmac_engine: CNT_W out of range");
      end
   endgenerate

   // Control fields
   logic   ctl_tcmask_q, ctl_en_q, ctl_dir_q, ctl_rst_q, ctl_ie_q;
   burst_e ctl_burst_q;
   logic   ep_q;

   logic              wr_csr, wr_addr, wr_cnt;
   logic              flush_stb, drain_stb, clr_state;
   logic              draining, drain_go, xfer_go, moved;
   logic [CNT_W-1:0]  count;
   logic              tc_w;
   logic [PC_W-1:0]   drain_cnt;
   logic [LEN_W-1:0]  bb;
   logic              ip_w;

   assign wr_csr  = bus_wr && (bus_sel == 2'(REG_CSR));
   assign wr_addr = bus_wr && (bus_sel == 2'(REG_ADDR));
   assign wr_cnt  = bus_wr && (bus_sel == 2'(REG_COUNT));

   assign flush_stb = wr_csr && bus_wdata[B_FLUSH];
   assign drain_stb = wr_csr && bus_wdata[B_DRAIN] && !ctl_rst_q;
   assign clr_state = ctl_rst_q || flush_stb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_tcmask_q <= 1'b0;
         ctl_burst_q  <= BURST_16;
         ctl_en_q     <= 1'b0;
         ctl_dir_q    <= 1'b0;
         ctl_rst_q    <= 1'b0;
         ctl_ie_q     <= 1'b0;
      end else if (wr_csr) begin
         ctl_tcmask_q <= bus_wdata[B_TCMASK];
         ctl_burst_q  <= burst_e'(bus_wdata[B_BURST+1:B_BURST]);
         ctl_en_q     <= bus_wdata[B_EN];
         ctl_dir_q    <= bus_wdata[B_DIR];
         ctl_rst_q    <= bus_wdata[B_RST];
         ctl_ie_q     <= bus_wdata[B_IE];
      end
   end

   // Slave error / error pending: stops the channel until cleared
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  ep_q <= 1'b0;
      else if (clr_state)          ep_q <= 1'b0;
      else if (mem_req && mem_err) ep_q <= 1'b1;
   end

   // Request generation
   always_comb begin
      draining = (drain_cnt != '0);
      drain_go = draining && !ctl_rst_q && !ep_q;
      xfer_go  = ctl_en_q && !ctl_rst_q && !ep_q && !draining && (count != '0);
      mem_req  = drain_go || xfer_go;
      bb       = burst_bytes(ctl_burst_q);
      if (drain_go)                  mem_len = LEN_W'(1);
      else if (count < CNT_W'(bb))   mem_len = LEN_W'(count);
      else                           mem_len = bb;
      moved    = mem_req && mem_ack && !mem_err;
   end

   assign mem_wr = ctl_dir_q;

   dmac_addr_ctr #(
      .ADDR_W (ADDR_W),
      .INC_W  (INC_W),
      .STEP_W (LEN_W)
   ) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (wr_addr),
      .ld_val (bus_wdata[ADDR_W-1:0]),
      .adv    (moved),
      .step   (mem_len),
      .addr   (mem_addr)
   );

   dmac_byte_ctr #(
      .CNT_W  (CNT_W),
      .STEP_W (LEN_W)
   ) u_count (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (wr_cnt),
      .ld_val (bus_wdata[CNT_W-1:0]),
      .dec    (moved),
      .step   (mem_len),
      .clr_tc (clr_state),
      .count  (count),
      .tc     (tc_w)
   );

   dmac_pack #(
      .PC_W (PC_W)
   ) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr_state),
      .push      (dev_push && ctl_en_q && ctl_dir_q && !ctl_rst_q),
      .drain     (drain_stb),
      .take      (moved && drain_go),
      .drain_cnt (drain_cnt)
   );

   // Flags and interrupt
   assign ip_w = dev_irq || (tc_w && !ctl_tcmask_q);
   assign irq  = ctl_ie_q && (ip_w || ep_q);

   // Register read mux
   always_comb begin
      bus_rdata = '0;
      case (reg_e'(bus_sel))
         REG_CSR: begin
            bus_rdata[B_REV_LO+3:B_REV_LO]   = REV;
            bus_rdata[B_TCMASK]              = ctl_tcmask_q;
            bus_rdata[B_BURST+1:B_BURST]     = ctl_burst_q;
            bus_rdata[B_TC]                  = tc_w;
            bus_rdata[B_EN]                  = ctl_en_q;
            bus_rdata[B_DIR]                 = ctl_dir_q;
            bus_rdata[B_RST]                 = ctl_rst_q;
            bus_rdata[B_DRAIN]               = ep_q;
            bus_rdata[B_IE]                  = ctl_ie_q;
            bus_rdata[B_DRN_LO+1:B_DRN_LO]   = drain_cnt;
            bus_rdata[B_EP]                  = ep_q;
            bus_rdata[B_IP]                  = ip_w;
         end
         REG_ADDR:  bus_rdata[ADDR_W-1:0] = mem_addr;
         REG_COUNT: bus_rdata[CNT_W-1:0]  = count;
         default:   bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/dmac_engine_chk.sv
module dmac_engine_chk #(
   parameter int ADDR_W = 32,
   parameter int INC_W  = 24,
   parameter int DATA_W = 32,
   parameter int LEN_W  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        bus_sel,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              mem_req,
   input logic              mem_ack,
   input logic              mem_err,
   input logic [LEN_W-1:0]  mem_len,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              irq,
   input logic              ctl_rst_q,
   input logic              ctl_ie_q,
   input logic              tc_w
);

   logic addr_wr, flush_wr;
   assign addr_wr  = bus_wr && (bus_sel == 2'd1);
   assign flush_wr = bus_wr && (bus_sel == 2'd0) && bus_wdata[5];

   assert_upper_addr_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_wr |=> $stable(mem_addr[ADDR_W-1:INC_W]));

   assert_tc_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tc_w) |-> $past(mem_req && mem_ack));

   assert_len_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_len != '0 && mem_len <= LEN_W'(32)));

   assert_no_req_in_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rst_q |-> !mem_req);

   assert_err_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_err && !flush_wr) |=> !mem_req);

   assert_irq_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ctl_ie_q);

endmodule

bind dmac_engine dmac_engine_chk #(
   .ADDR_W (ADDR_W),
   .INC_W  (INC_W),
   .DATA_W (DATA_W),
   .LEN_W  (dmac_pkg::LEN_W)
) u_dmac_engine_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .mem_req   (mem_req),
   .mem_ack   (mem_ack),
   .mem_err   (mem_err),
   .mem_len   (mem_len),
   .mem_addr  (mem_addr),
   .irq       (irq),
   .ctl_rst_q (ctl_rst_q),
   .ctl_ie_q  (ctl_ie_q),
   .tc_w      (tc_w)
);

// File: tb/test_dmac_engine.sv
`timescale 1ns/1ps
module test_dmac_engine;

   localparam logic [31:0] EN    = 32'h0000_0200;
   localparam logic [31:0] DIR   = 32'h0000_0100;
   localparam logic [31:0] RSTB  = 32'h0000_0080;
   localparam logic [31:0] DRAIN = 32'h0000_0040;
   localparam logic [31:0] FLUSH = 32'h0000_0020;
   localparam logic [31:0] IE    = 32'h0000_0010;
   localparam logic [31:0] MASK  = 32'h0080_0000;

   typedef struct packed {
      logic [1:0]  burst;
      logic [31:0] addr;
      logic [23:0] cnt;
      logic [5:0]  exp_len;
      logic [31:0] exp_addr;
      logic [23:0] exp_cnt;
      logic        exp_tc;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 32'h1000_0000, 24'd100, 6'd16, 32'h1000_0010, 24'd84, 1'b0},
      '{2'd1, 32'h2000_0100, 24'd100, 6'd32, 32'h2000_0120, 24'd68, 1'b0},
      '{2'd2, 32'h3000_0000, 24'd5,   6'd1,  32'h3000_0001, 24'd4,  1'b0},
      '{2'd3, 32'h3100_00FF, 24'd5,   6'd1,  32'h3100_0100, 24'd4,  1'b0},
      '{2'd0, 32'h44FF_FFF8, 24'd10,  6'd10, 32'h4400_0002, 24'd0,  1'b1},
      '{2'd1, 32'hABFF_FFF0, 24'd20,  6'd20, 32'hAB00_0004, 24'd0,  1'b1},
      '{2'd0, 32'h5500_0000, 24'd16,  6'd16, 32'h5500_0010, 24'd0,  1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_sel = 2'd0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        dev_push = 1'b0, dev_irq = 1'b0;
   logic        mem_req, mem_wr, irq;
   logic [31:0] mem_addr;
   logic [5:0]  mem_len;
   logic        mem_ack = 1'b0, mem_err = 1'b0;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   dmac_engine i_dmac_engine (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_push(dev_push),
      .dev_irq(dev_irq), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_len(mem_len), .mem_wr(mem_wr), .mem_ack(mem_ack),
      .mem_err(mem_err), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
      tick();
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] sel, output logic [31:0] d);
      bus_sel = sel;
      #1;
      d = bus_rdata;
   endtask

   task automatic ack(input logic err);
      mem_ack = 1'b1; mem_err = err;
      tick();
      mem_ack = 1'b0; mem_err = 1'b0;
   endtask

   task automatic push(input int n);
      for (int k = 0; k < n; k++) begin
         dev_push = 1'b1;
         tick();
      end
      dev_push = 1'b0;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         finish_run();
      end
   end

   initial begin
      logic [31:0] r;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // Reset state
      rd(2'd0, r); check("R1 reset csr", r, 32'hA000_0000);
      rd(2'd1, r); check("R12 reset addr", r, 32'h0);
      rd(2'd2, r); check("R12 reset count", r, 32'h0);
      check("R5 reset req", {31'b0, mem_req}, 32'd0);
      check("R11 reset irq", {31'b0, irq}, 32'd0);

      // R1: all writable and reserved bits set, reset bit left 0
      wr(2'd0, 32'hFFFF_FF7F);
      rd(2'd0, r); check("R1 rw/ro mask", r, 32'hA08C_0310);
      wr(2'd0, 32'h0);
      // R12: diagnostic word
      wr(2'd3, 32'h1234_5678);
      rd(2'd3, r); check("R12 diag reads zero", r, 32'h0);

      // Vector walk: R2, R3, R4
      for (int i = 0; i < NV; i++) begin
         wr(2'd0, EN | FLUSH | (32'(VECS[i].burst) << 18));
         wr(2'd1, VECS[i].addr);
         wr(2'd2, 32'(VECS[i].cnt));
         check("R4 burst len", 32'(mem_len), 32'(VECS[i].exp_len));
         check("R5 req", {31'b0, mem_req}, 32'd1);
         ack(1'b0);
         rd(2'd1, r); check("R2 addr advance", r, VECS[i].exp_addr);
         rd(2'd2, r); check("R3 count", r, 32'(VECS[i].exp_cnt));
         rd(2'd0, r); check("R3 tc flag", {31'b0, r[14]}, {31'b0, VECS[i].exp_tc});
      end

      // R11: terminal count is set from the last vector
      wr(2'd0, IE);
      rd(2'd0, r); check("R11 ip from tc", {31'b0, r[0]}, 32'd1);
      check("R11 irq", {31'b0, irq}, 32'd1);
      wr(2'd0, IE | MASK);
      rd(2'd0, r); check("R11 mask hides ip", {31'b0, r[0]}, 32'd0);
      check("R3 tc kept under mask", {31'b0, r[14]}, 32'd1);
      check("R11 masked irq", {31'b0, irq}, 32'd0);
      dev_irq = 1'b1;
      rd(2'd0, r); check("R11 dev irq", {31'b0, r[0]}, 32'd1);
      check("R11 dev irq out", {31'b0, irq}, 32'd1);
      wr(2'd0, 32'h0);
      check("R11 ie off", {31'b0, irq}, 32'd0);
      dev_irq = 1'b0;

      // R6: sticky reset
      wr(2'd0, EN | RSTB);
      tick();
      rd(2'd0, r); check("R6 tc cleared", {31'b0, r[14]}, 32'd0);
      wr(2'd2, 32'd40);
      check("R6 no req in reset", {31'b0, mem_req}, 32'd0);
      repeat (3) tick();
      rd(2'd0, r); check("R6 sticky bit", {31'b0, r[7]}, 32'd1);
      wr(2'd0, EN);
      check("R6 req after release", {31'b0, mem_req}, 32'd1);
      check("R5 dir 0", {31'b0, mem_wr}, 32'd0);

      // R5
      wr(2'd0, EN | DIR);
      check("R5 dir 1", {31'b0, mem_wr}, 32'd1);
      wr(2'd0, DIR);
      check("R5 disabled", {31'b0, mem_req}, 32'd0);

      // R10: slave error
      wr(2'd0, EN | IE);
      wr(2'd1, 32'h0600_0000);
      ack(1'b1);
      check("R10 halted", {31'b0, mem_req}, 32'd0);
      rd(2'd0, r); check("R10 ep and serr", r & 32'h42, 32'h42);
      check("R10 irq", {31'b0, irq}, 32'd1);
      rd(2'd1, r); check("R10 addr unmoved", r, 32'h0600_0000);
      rd(2'd2, r); check("R10 count unmoved", r, 32'd40);
      ack(1'b0);
      rd(2'd2, r); check("R10 ack ignored", r, 32'd40);
      wr(2'd0, EN | IE | FLUSH);
      rd(2'd0, r); check("R7 flush clears err", r & 32'h42, 32'h0);
      check("R7 req resumes", {31'b0, mem_req}, 32'd1);

      // R9: pushes ignored with direction 0
      wr(2'd2, 32'd0);
      wr(2'd0, EN);
      push(2);
      wr(2'd0, EN | DIR | DRAIN);
      rd(2'd0, r); check("R9 push ignored dir0", 32'(r[3:2]), 32'd0);

      // R8: drain of three packed bytes
      wr(2'd1, 32'h0700_0000);
      push(3);
      wr(2'd0, EN | DIR | DRAIN);
      rd(2'd0, r); check("R8 drain count", 32'(r[3:2]), 32'd3);
      check("R8 bit6 reads serr", {31'b0, r[6]}, 32'd0);
      check("R8 single byte", 32'(mem_len), 32'd1);
      check("R8 req", {31'b0, mem_req}, 32'd1);
      ack(1'b0);
      rd(2'd0, r); check("R8 drain step", 32'(r[3:2]), 32'd2);
      rd(2'd1, r); check("R8 addr step", r, 32'h0700_0001);
      wr(2'd0, EN | DIR | FLUSH);
      rd(2'd0, r); check("R7 flush clears drain", 32'(r[3:2]), 32'd0);
      check("R7 no req", {31'b0, mem_req}, 32'd0);

      // R9: pack count wraps modulo 4
      push(5);
      wr(2'd0, EN | DIR | DRAIN);
      rd(2'd0, r); check("R9 wrap", 32'(r[3:2]), 32'd1);
      ack(1'b0);
      rd(2'd0, r); check("R8 drain done", 32'(r[3:2]), 32'd0);
      check("R8 idle", {31'b0, mem_req}, 32'd0);

      done = 1'b1;
      finish_run();
   end

endmodule